// File: doc/BRIEF.md
# Page write buffer engine

This block sits behind a serial-bus slave front end inside a small non-volatile memory model. The front end decodes the bus and passes three things to the block: the starting byte address, each received data byte as a one-cycle strobe, and a commit strobe when the bus transaction ends with a STOP. The block collects the bytes in a one-page buffer. The page is 16 bytes at the default sizes, and the byte address is 10 bits, giving 64 pages.

While bytes are loaded, the low address bits advance and wrap inside the page, so the page number never changes. On commit, all buffered bytes are transferred to the memory array in a single timed write cycle. A busy flag stays high for the whole cycle, and the front end uses it to refuse its slave address. A write-protect input cancels the commit. A STOP that arrives before any data byte also cancels it.

The write cycle has a fixed length of `WR_CYCLES` clocks. During its first `2**OFS_W` clocks, the buffer is copied out through a registered write port, at most one byte per clock. Only the offsets that were actually loaded are written.

Top module: `pgw_engine`

## Requirements
- R1: Synchronous reset gives `busy`=0, `mem_we`=0, `cur_addr`=0.
- R2: When idle and `commit` is low, `addr_ld` makes `cur_addr` equal `addr_in` after the next clock edge and empties the buffer.
- R3: When idle and neither `commit` nor `addr_ld` is high, `byte_vld` stores `byte_in` at buffer offset `cur_addr[3:0]`. It then sets `cur_addr[3:0]` to `(cur_addr[3:0]+1) mod 16` and leaves `cur_addr[9:4]` (the page) unchanged.
- R4: `commit` while idle, with at least one byte loaded and `wp` low, raises `busy` at the next edge. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R5: During that cycle, each loaded offset o is written once to memory address `{page, o}` with the last byte stored at o. The writes appear in increasing o order, with `mem_we` high in the cycle that is `o+1` clocks after `busy` rises. No other address is written.
- R6: `commit` with an empty buffer starts no write cycle, and `busy` stays low.
- R7: `commit` with `wp` high writes nothing and never raises `busy`. The loaded bytes are discarded.
- R8: While `busy` is high, `addr_ld`, `byte_vld` and `commit` have no effect: `cur_addr` and memory are unchanged.
- R9: After a write cycle or a dropped commit, the buffer is empty, so a further `commit` with no new bytes does nothing.
- R10: `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load start address strobe |
| addr_in | input | ADDR_W | Start byte address |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | DATA_W | Data byte |
| commit | input | 1 | STOP seen: commit the buffer |
| wp | input | 1 | Write protect, high blocks all writes |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | ADDR_W | Current byte address |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The assertions check every cycle that:
- write strobes fall inside the busy window;
- each busy window is exactly `WR_CYCLES` long;
- the address register holds still while busy;
- loads and in-page steps move the address correctly;
- a protected commit never raises busy.

Only the bench scenarios can show the remaining behaviours. These are whether the right bytes land at the right addresses, and the effects of overwrite after a full-page wrap, the empty-buffer STOP, and buffer clearing after a dropped commit. The bench shows them by comparing the memory it holds against a behavioural model after each transaction.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_HOLD  = 2'd2
  } pgw_seq_e;
endpackage

// File: rtl/pgw_addr.sv
// Current byte address register with in-page increment.
module pgw_addr #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] cur
);
  localparam int PG_W = ADDR_W - OFS_W;

  logic [PG_W-1:0]  page_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (ld) begin
      page_q <= ld_addr[ADDR_W-1:OFS_W];
      ofs_q  <= ld_addr[OFS_W-1:0];
    end else if (step) begin
      ofs_q  <= ofs_q + 1'b1;   // wraps inside the page
    end
  end

  assign cur = {page_q, ofs_q};
endmodule

// File: rtl/pgw_buf.sv
// One-page byte buffer with per-offset valid mask and registered read port.
module pgw_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              any
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  // data array: no reset, single write and single registered read
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ofs] <= wr_data;
    rd_data <= store[rd_ofs];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_en & mask_q[rd_ofs];
      if (clr)        mask_q <= '0;
      else if (wr_en) mask_q[wr_ofs] <= 1'b1;
    end
  end

  assign any = |mask_q;
endmodule

// File: rtl/pgw_seq.sv
// Timed write-cycle sequencer: drains the page, then holds busy to length.
module pgw_seq import pgw_pkg::*; #(
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             drain_en,
  output logic [OFS_W-1:0] drain_idx,
  output logic             drain_last
);
  localparam int DEPTH = 1 << OFS_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WR_CYCLES - 1);

  pgw_seq_e         state_q;
  logic [OFS_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_DRAIN;
          idx_q   <= '0;
          cnt_q   <= '0;
          busy_q  <= 1'b1;
        end
        SEQ_DRAIN: begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (idx_q == OFS_W'(DEPTH - 1)) state_q <= SEQ_HOLD;
        end
        SEQ_HOLD: begin
          if (cnt_q == CNT_END) begin
            state_q <= SEQ_IDLE;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign drain_en   = (state_q == SEQ_DRAIN);
  assign drain_idx  = idx_q;
  assign drain_last = drain_en && (idx_q == OFS_W'(DEPTH - 1));
endmodule

// File: rtl/pgw_engine.sv
// Page write buffer engine top. WR_CYCLES must be at least 2**OFS_W + 1.
module pgw_engine #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              commit,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic             idle, do_commit, start, drop, ld, wr, clr, any;
  logic             drain_en, drain_last;
  logic [OFS_W-1:0] drain_idx;

  assign idle      = ~busy;
  assign do_commit = idle & commit;
  assign start     = do_commit & any & ~wp;
  assign drop      = do_commit & ~start;
  assign ld        = idle & ~commit & addr_ld;
  assign wr        = idle & ~commit & ~addr_ld & byte_vld;
  assign clr       = ld | drop | drain_last;

  pgw_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .clk(clk), .rst(rst), .ld(ld), .ld_addr(addr_in), .step(wr), .cur(cur_addr)
  );

  pgw_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr), .wr_ofs(cur_addr[OFS_W-1:0]),
    .wr_data(byte_in), .clr(clr), .rd_en(drain_en), .rd_ofs(drain_idx),
    .rd_vld(mem_we), .rd_data(mem_wdata), .any(any)
  );

  pgw_seq #(.OFS_W(OFS_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .drain_en(drain_en),
    .drain_idx(drain_idx), .drain_last(drain_last)
  );

  // page bits cannot move while busy, so the write address pairs them with the drain index
  always_ff @(posedge clk) begin
    if (rst) mem_addr <= '0;
    else     mem_addr <= {cur_addr[ADDR_W-1:OFS_W], drain_idx};
  end
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int ADDR_W    = 10,
  parameter int OFS_W     = 4,
  parameter int WR_CYCLES = 800
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_ld,
  input logic [ADDR_W-1:0] addr_in,
  input logic              byte_vld,
  input logic              commit,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_cnt == WR_CYCLES);

  assert_busy_max_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_cnt < WR_CYCLES);

  assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (commit && !busy && wp) |=> !busy);

  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cur_addr));

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_ld && !busy && !commit) |=> cur_addr == $past(addr_in));

  assert_page_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !addr_ld && !busy && !commit) |=>
      (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W])) &&
      (cur_addr[OFS_W-1:0] == $past(cur_addr[OFS_W-1:0]) + 1'b1));
endmodule

bind pgw_engine pgw_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in), .byte_vld(byte_vld),
  .commit(commit), .wp(wp), .busy(busy), .cur_addr(cur_addr), .mem_we(mem_we)
);

// File: tb/sim_pgw_engine.sv
`timescale 1ns/1ps
module sim_pgw_engine;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int OW = 4;
  localparam int WC = 800;
  localparam int PG = 1 << OW;
  localparam int MS = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic addr_ld = 0, byte_vld = 0, commit = 0, wp = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_in = '0;
  logic busy, mem_we;
  logic [AW-1:0] cur_addr, mem_addr;
  logic [DW-1:0] mem_wdata;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  pgw_engine #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .WR_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in), .byte_vld(byte_vld),
    .byte_in(byte_in), .commit(commit), .wp(wp), .busy(busy), .cur_addr(cur_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #2.5 clk = ~clk;

  // memory array driven by the block's write port, and the model's expectation
  byte unsigned bmem [MS];
  byte unsigned xmem [MS];

  // behavioural reference model
  bit  m_busy; int m_cnt; int m_cur; int m_page;
  bit  m_mask [PG]; byte unsigned m_buf [PG];
  bit  d_mask [PG]; byte unsigned d_buf [PG];

  function automatic bit m_any();
    for (int i = 0; i < PG; i++) if (m_mask[i]) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < MS; i++) begin bmem[i] = 0; xmem[i] = 0; end
  end

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr] = mem_wdata;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_cur = 0;
      for (int i = 0; i < PG; i++) m_mask[i] = 0;
    end else if (m_busy) begin
      if (m_cnt == WC - 1) m_busy = 0; else m_cnt++;
    end else if (commit) begin
      if (m_any() && !wp) begin
        m_busy = 1; m_cnt = 0; m_page = m_cur / PG;
        for (int i = 0; i < PG; i++) begin
          d_mask[i] = m_mask[i]; d_buf[i] = m_buf[i];
          if (m_mask[i]) xmem[m_page*PG + i] = m_buf[i];
        end
      end
      for (int i = 0; i < PG; i++) m_mask[i] = 0;
    end else if (addr_ld) begin
      m_cur = int'(addr_in);
      for (int i = 0; i < PG; i++) m_mask[i] = 0;
    end else if (byte_vld) begin
      m_buf[m_cur % PG] = byte_in; m_mask[m_cur % PG] = 1;
      m_cur = (m_cur / PG) * PG + ((m_cur + 1) % PG);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit xwe; int xo;
      xwe = m_busy && m_cnt >= 1 && m_cnt <= PG && d_mask[m_cnt-1];
      xo  = (m_cnt >= 1 && m_cnt <= PG) ? m_cnt - 1 : 0;
      chk(busy == m_busy, "R4 busy", int'(busy), int'(m_busy));
      chk(int'(cur_addr) == m_cur, "R3 cur_addr", int'(cur_addr), m_cur);
      chk(mem_we == xwe, "R5/R10 mem_we", int'(mem_we), int'(xwe));
      if (xwe) begin
        chk(int'(mem_addr) == m_page*PG + xo, "R5 mem_addr", int'(mem_addr), m_page*PG + xo);
        chk(mem_wdata == d_buf[xo], "R5 mem_wdata", int'(mem_wdata), int'(d_buf[xo]));
      end
    end
  end

  task automatic pulse_ld(int a);
    @(negedge clk); #1 addr_ld = 1; addr_in = AW'(a);
    @(negedge clk); #1 addr_ld = 0;
  endtask
  task automatic pulse_byte(int d);
    @(negedge clk); #1 byte_vld = 1; byte_in = DW'(d);
    @(negedge clk); #1 byte_vld = 0;
  endtask
  task automatic pulse_commit();
    @(negedge clk); #1 commit = 1;
    @(negedge clk); #1 commit = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    #1;
  endtask
  task automatic mem_cmp(string req);
    int nbad = 0, fa = 0;
    for (int i = 0; i < MS; i++) if (bmem[i] != xmem[i]) begin
      if (nbad == 0) fa = i;
      nbad++;
    end
    chk(nbad == 0, req, int'(bmem[fa]), int'(xmem[fa]));
  endtask

  initial begin
    int n;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(mem_we == 0, "R1 mem_we", int'(mem_we), 0);
    chk(cur_addr == 0, "R1 cur_addr", int'(cur_addr), 0);
    #1 rst = 0;

    // R2/R4/R5: four bytes mid-page
    pulse_ld('h123);
    chk(cur_addr == 'h123, "R2 load", int'(cur_addr), 'h123);
    for (int i = 0; i < 4; i++) pulse_byte('hA0 + i);
    pulse_commit();
    chk(busy == 1, "R4 rise", int'(busy), 1);
    wait_idle(n);
    chk(n == WC, "R4 length", n, WC);
    mem_cmp("R5 mid-page");

    // R3: wrap from offset 14 into the same page
    pulse_ld('h05E);
    for (int i = 0; i < 5; i++) pulse_byte('h10 + i);
    chk(cur_addr == 'h053, "R3 wrap addr", int'(cur_addr), 'h053);
    pulse_commit(); wait_idle(n);
    mem_cmp("R3 wrap data");

    // R5: 20 bytes over a full page, overwrite of first four
    pulse_ld('h3F0);
    for (int i = 0; i < 20; i++) pulse_byte('h40 + i);
    chk(cur_addr == 'h3F4, "R3 full wrap addr", int'(cur_addr), 'h3F4);
    pulse_commit(); wait_idle(n);
    mem_cmp("R5 overwrite");

    // R6: STOP after address only
    pulse_ld('h200);
    pulse_commit();
    chk(busy == 0, "R6 no busy", int'(busy), 0);
    mem_cmp("R6 no write");

    // R7 then R9: protected commit, then empty re-commit
    pulse_ld('h080);
    for (int i = 0; i < 3; i++) pulse_byte('hC0 + i);
    @(negedge clk); #1 wp = 1;
    pulse_commit();
    chk(busy == 0, "R7 no busy", int'(busy), 0);
    mem_cmp("R7 no write");
    wp = 0;
    pulse_commit();
    chk(busy == 0, "R9 empty after drop", int'(busy), 0);
    mem_cmp("R9 no write");

    // R8: activity during busy is ignored
    pulse_ld('h3FF);
    pulse_byte('h77); pulse_byte('h78);
    chk(cur_addr == 'h3F1, "R3 last addr wrap", int'(cur_addr), 'h3F1);
    pulse_commit();
    pulse_ld('h001); pulse_byte('h99); pulse_commit();
    chk(cur_addr == 'h3F1, "R8 addr frozen", int'(cur_addr), 'h3F1);
    wait_idle(n);
    mem_cmp("R8 memory");
    pulse_commit();
    chk(busy == 0, "R9 empty after write", int'(busy), 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule